// File: doc/BRIEF.md
# Conversion-Clocked Serial ADC Reader

This block is the host-side controller for a 16-bit successive-approximation converter whose conversion clock also shifts the result out. Each result bit is captured while the converter is still deciding the bits below it, so no separate transfer burst follows the conversion. A parameterized divider derives the converter clock from the system clock. After system reset the block holds the converter in reset for a few converter clocks and then runs the calibration phase. That phase ends after a fixed number of converter clocks, or earlier on a synchronized end-of-conversion low if the host selects that option.

Once calibrated, a single-cycle start request opens a frame. Chip select and the convert strobe go low together on a falling converter edge. The frame lasts a fixed number of converter clocks, and the 16 result bits are captured either on rising edges or one half period later on falling edges. The first bit seen in the frame is left over from the previous result and is thrown away. A programmable system-clock timeout aborts a frame that runs too long.

Top module: `adc_sync_reader`

## Requirements
- R1: `adc_clk` is low in reset and toggles every DIV system clocks from reset release onward, giving a period of 2*DIV system clocks.
- R2: During reset `adc_rst_n` is low, `adc_cs_n` and `adc_conv_n` are high, `busy` is 1 and `rd_valid`, `tmo_err` and `rd_data` are 0. After release, `adc_rst_n` stays low until the RST_CLKS-th rising `adc_clk` edge and goes high on that edge. `busy` stays 1 whenever `adc_rst_n` is low.
- R3: With `cal_on_eoc`=0, calibration ends and `busy` falls on exactly the CAL_CLKS-th rising `adc_clk` edge after `adc_rst_n` went high (default 14000). `adc_eoc` has no effect on this timing.
- R4: With `cal_on_eoc`=1, a low level on `adc_eoc` (low means calibration done) ends calibration. It is seen once at least EOC_GUARD calibration clocks have passed, and `busy` falls on the third system clock edge after `adc_eoc` goes low. The CAL_CLKS count remains a fallback.
- R5: A start pulse while idle sets `busy` on the next system clock edge. `adc_cs_n` and `adc_conv_n` then fall on the same edge as a falling `adc_clk`. `adc_conv_n` returns high on the first rising `adc_clk` of the frame.
- R6: `adc_cs_n` stays low for exactly CONV_CLKS (default 20) rising `adc_clk` edges and returns high with the falling edge that closes the last cycle.
- R7: Counting frame cycles from 0 at the first rising edge, the bit in cycle 0 is discarded. Cycles 1 to 16 carry result bits 15 down to 0, MSB first. With `cap_fall`=0 each bit is sampled at its rising edge, and `rd_data` bit 15 holds the first stored bit.
- R8: With `cap_fall`=1 each bit is sampled at the falling edge that ends its cycle, giving the same result as R7. The mode is latched when a start is accepted.
- R9: `rd_valid` is high for exactly one system clock, on the edge where `adc_cs_n` rises at the end of a full frame, and `rd_data` carries the new result then. `rd_data` holds its value until the next valid result.
- R10: A start pulse during calibration or during a conversion is ignored; no extra frame follows.
- R11: If a conversion is still running `tmo_lim` system clocks after its start was accepted, the frame is aborted: `adc_cs_n` and `adc_conv_n` go high, `busy` falls, `tmo_err` pulses for one clock, and `rd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, one cycle |
| cap_fall | input | 1 | 1: sample on falling converter edge, 0: rising |
| cal_on_eoc | input | 1 | 1: end calibration early on end-of-conversion low |
| tmo_lim | input | TMO_W | Conversion timeout in system clocks |
| busy | output | 1 | Calibrating or converting |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_data | output | DW | Last result |
| tmo_err | output | 1 | One-cycle timeout strobe |
| adc_clk | output | 1 | Converter and data clock |
| adc_rst_n | output | 1 | Converter reset, active low |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_conv_n | output | 1 | Convert strobe, active low |
| adc_eoc | input | 1 | Converter end-of-conversion flag |
| adc_dout | input | 1 | Converter serial data |

## Verification
Each result has a fixed latency in system clocks, counted from a visible event at the pins. `busy` rises one edge after start. The calibration end lands on the same edge as the 14000th converter rise, or three edges after the end-of-conversion flag drops. `rd_valid` coincides with the `adc_cs_n` rise, and `tmo_err` comes exactly `tmo_lim` edges after `busy` rose. A behavioural converter model in the bench follows the pins on every falling system clock and reacts to them. It keeps its own counts of rises, falls and elapsed clocks, and compares each output against the cycle where that count says it is due, so an early or late edge fails on the cycle it happens.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_RST  = 3'd0,
    ST_CAL  = 3'd1,
    ST_IDLE = 3'd2,
    ST_WAIT = 3'd3,
    ST_CONV = 3'd4
  } rd_state_e;
endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic clk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q, div_d;
  logic          lvl_q, lvl_d;
  logic          tick;

  always_comb begin
    tick  = (div_q == DW'(DIV - 1));
    div_d = tick ? '0 : div_q + 1'b1;
    lvl_d = lvl_q ^ tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      div_q <= div_d;
      lvl_q <= lvl_d;
    end
  end

  assign clk_o  = lvl_q;
  assign rise_o = tick & ~lvl_q;
  assign fall_o = tick & lvl_q;

  // R1
  clk_toggle_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_o != $past(clk_o)) |=> (clk_o == $past(clk_o)) || (DIV == 1));
endmodule

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/adc_bit_capture.sv
module adc_bit_capture #(
  parameter int W  = 16,
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rise,
  input  logic          fall,
  input  logic          on_fall,
  input  logic          din,
  input  logic [CW-1:0] cyc,
  output logic [W-1:0]  word
);
  logic [W-1:0] word_q, word_d;
  logic         take;

  always_comb begin
    if (on_fall)
      take = fall && (cyc >= CW'(2)) && (cyc <= CW'(W + 1));
    else
      take = rise && (cyc >= CW'(1)) && (cyc <= CW'(W));
    if (clr)
      word_d = '0;
    else if (take)
      word_d = {word_q[W-2:0], din};
    else
      word_d = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/adc_sync_reader.sv
module adc_sync_reader
  import adc_rd_pkg::*;
#(
  parameter int DW        = 16,
  parameter int DIV       = 4,
  parameter int RST_CLKS  = 4,
  parameter int CAL_CLKS  = 14000,
  parameter int CONV_CLKS = 20,
  parameter int EOC_GUARD = 4,
  parameter int TMO_W     = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cap_fall,
  input  logic             cal_on_eoc,
  input  logic [TMO_W-1:0] tmo_lim,
  output logic             busy,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             tmo_err,
  output logic             adc_clk,
  output logic             adc_rst_n,
  output logic             adc_cs_n,
  output logic             adc_conv_n,
  input  logic             adc_eoc,
  input  logic             adc_dout
);
  localparam int CMAX_A = (CAL_CLKS > CONV_CLKS) ? CAL_CLKS : CONV_CLKS;
  localparam int CMAX   = (CMAX_A > RST_CLKS) ? CMAX_A : RST_CLKS;
  localparam int CW     = $clog2(CMAX + 1);

  rd_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [TMO_W-1:0] tmr_q, tmr_d;
  logic             rstp_q, rstp_d;
  logic             cs_n_q, cs_n_d;
  logic             conv_n_q, conv_n_d;
  logic             valid_q, valid_d;
  logic             err_q, err_d;
  logic             mode_q, mode_d;
  logic [DW-1:0]    data_q, data_d;

  logic             clk_lvl, clk_rise, clk_fall;
  logic             eoc_s;
  logic             cap_clr;
  logic             in_conv;
  logic [DW-1:0]    cap_word;

  adc_clk_gen #(.DIV(DIV)) i_clk_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_o  (clk_lvl),
    .rise_o (clk_rise),
    .fall_o (clk_fall)
  );

  adc_eoc_sync i_eoc_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (adc_eoc),
    .sync_o  (eoc_s)
  );

  assign in_conv = (state_q == ST_CONV);

  adc_bit_capture #(.W(DW), .CW(CW)) i_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cap_clr),
    .rise    (clk_rise & in_conv),
    .fall    (clk_fall & in_conv),
    .on_fall (mode_q),
    .din     (adc_dout),
    .cyc     (cnt_q),
    .word    (cap_word)
  );

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    tmr_d    = tmr_q;
    rstp_d   = rstp_q;
    cs_n_d   = cs_n_q;
    conv_n_d = conv_n_q;
    mode_d   = mode_q;
    data_d   = data_q;
    valid_d  = 1'b0;
    err_d    = 1'b0;
    cap_clr  = 1'b0;

    unique case (state_q)
      ST_RST: begin
        if (clk_rise) begin
          if (cnt_q == CW'(RST_CLKS - 1)) begin
            cnt_d   = '0;
            rstp_d  = 1'b1;
            state_d = ST_CAL;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_CAL: begin
        if (cal_on_eoc && !eoc_s && (cnt_q >= CW'(EOC_GUARD))) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end else if (clk_rise) begin
          if (cnt_q == CW'(CAL_CLKS - 1)) begin
            cnt_d   = '0;
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_IDLE: begin
        if (start) begin
          tmr_d   = '0;
          mode_d  = cap_fall;
          cap_clr = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT, ST_CONV: begin
        if (tmr_q == TMO_W'(tmo_lim - 1'b1)) begin
          cs_n_d   = 1'b1;
          conv_n_d = 1'b1;
          err_d    = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          tmr_d = tmr_q + 1'b1;
          if (state_q == ST_WAIT) begin
            if (clk_fall) begin
              cs_n_d   = 1'b0;
              conv_n_d = 1'b0;
              cnt_d    = '0;
              state_d  = ST_CONV;
            end
          end else begin
            if (clk_rise) begin
              cnt_d    = cnt_q + 1'b1;
              conv_n_d = 1'b1;
            end
            if (clk_fall && (cnt_q == CW'(CONV_CLKS))) begin
              cs_n_d  = 1'b1;
              valid_d = 1'b1;
              data_d  = cap_word;
              state_d = ST_IDLE;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RST;
      cnt_q    <= '0;
      tmr_q    <= '0;
      rstp_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      conv_n_q <= 1'b1;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      mode_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      tmr_q    <= tmr_d;
      rstp_q   <= rstp_d;
      cs_n_q   <= cs_n_d;
      conv_n_q <= conv_n_d;
      valid_q  <= valid_d;
      err_q    <= err_d;
      mode_q   <= mode_d;
      data_q   <= data_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign rd_valid   = valid_q;
  assign rd_data    = data_q;
  assign tmo_err    = err_q;
  assign adc_clk    = clk_lvl;
  assign adc_rst_n  = rstp_q;
  assign adc_cs_n   = cs_n_q;
  assign adc_conv_n = conv_n_q;

  // R2
  rst_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rst_n |-> busy);

  // R5
  cs_fall_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $fell(adc_clk));

  // R5
  conv_only_at_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_conv_n) |-> $fell(adc_cs_n));

  // R9
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R9
  valid_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($rose(adc_cs_n) && !busy));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

  // R11
  tmo_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (!rd_valid && adc_cs_n && adc_conv_n && !busy));
endmodule

// File: tb/test_adc_sync_reader.sv
module test_adc_sync_reader;
  localparam int DW    = 16;
  localparam int DIV   = 2;
  localparam int RSTC  = 4;
  localparam int CAL   = 14000;
  localparam int CONV  = 20;
  localparam int TMO_W = 21;

  logic             clk, rst_n, start, cap_fall, cal_on_eoc;
  logic [TMO_W-1:0] tmo_lim;
  logic             busy, rd_valid, tmo_err;
  logic [DW-1:0]    rd_data;
  logic             adc_clk, adc_rst_n, adc_cs_n, adc_conv_n;
  logic             adc_eoc, adc_dout;

  adc_sync_reader #(
    .DW(DW), .DIV(DIV), .RST_CLKS(RSTC), .CAL_CLKS(CAL),
    .CONV_CLKS(CONV), .EOC_GUARD(4), .TMO_W(TMO_W)
  ) i_adc_sync_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_fall(cap_fall),
    .cal_on_eoc(cal_on_eoc), .tmo_lim(tmo_lim), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .tmo_err(tmo_err),
    .adc_clk(adc_clk), .adc_rst_n(adc_rst_n), .adc_cs_n(adc_cs_n),
    .adc_conv_n(adc_conv_n), .adc_eoc(adc_eoc), .adc_dout(adc_dout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // configuration written by the stimulus only while it cannot be read
  logic [DW-1:0] cur_word;
  bit            expect_tmo;
  int            tmo_L;
  int            eoc_drop_cfg;

  // model state
  int            n, rst_rises, cal_rises, drop_n, age, k, fr_rises;
  int            frames_started, frames_done, tmo_hits, cal_ends;
  bit            cal_active;
  logic          prev_clk, prev_cs, prev_rstn, prev_busy, prev_b15;
  logic [DW-1:0] frame_word, last_word;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      n = 0; rst_rises = 0; cal_rises = 0; drop_n = -100; age = 0;
      k = 0; fr_rises = 0; cal_active = 0;
      prev_clk = 1'b0; prev_cs = 1'b1; prev_rstn = 1'b0; prev_busy = 1'b1;
      prev_b15 = 1'b0; last_word = '0; frame_word = '0;
      adc_eoc = 1'b1; adc_dout = 1'b0;
    end else begin
      bit rose_c, fell_c, cs_fell, cs_rose, exp_err;
      n++;
      // R1
      chk(adc_clk == 1'(((n / DIV) % 2)), "R1", adc_clk, (n / DIV) % 2);
      rose_c = adc_clk && !prev_clk;
      fell_c = !adc_clk && prev_clk;

      if (rose_c && !prev_rstn) rst_rises++;
      if (adc_rst_n && !prev_rstn) begin
        // R2
        chk(rst_rises == RSTC && rose_c, "R2", rst_rises, RSTC);
        cal_active = 1; cal_rises = 0;
      end
      if (rose_c && prev_rstn && cal_active) cal_rises++;
      if (cal_active && adc_eoc && cal_rises >= eoc_drop_cfg) begin
        adc_eoc = 1'b0; drop_n = n;
      end
      if (cal_active && !busy) begin
        cal_active = 0; cal_ends++;
        if (cal_on_eoc) begin
          // R4
          chk(n == drop_n + 3, "R4", n - drop_n, 3);
        end else begin
          // R3
          chk(cal_rises == CAL && rose_c, "R3", cal_rises, CAL);
        end
        // R10
        chk(frames_started == 0, "R10", frames_started, 0);
      end

      if (busy && !prev_busy) age = 0; else age++;
      exp_err = expect_tmo && (age == tmo_L);
      if (tmo_err) tmo_hits++;
      // R11
      chk(tmo_err == exp_err, "R11", tmo_err, exp_err);

      cs_fell = !adc_cs_n && prev_cs;
      cs_rose = adc_cs_n && !prev_cs;
      if (cs_fell) begin
        frames_started++;
        // R5
        chk(fell_c, "R5", adc_clk, 0);
        // R9
        chk(rd_data == last_word, "R9", rd_data, last_word);
        frame_word = cur_word; k = 0; fr_rises = 0;
      end
      if (!adc_cs_n) begin
        if (rose_c) fr_rises++;
        if (fell_c && !cs_fell) begin
          k++;
          adc_dout = (k >= 1 && k <= DW) ? frame_word[DW - k] : 1'b0;
        end
        // R5
        chk(adc_conv_n == (fr_rises > 0), "R5", adc_conv_n, fr_rises > 0);
      end
      if (cs_rose) begin
        if (!expect_tmo) begin
          // R6
          chk(fr_rises == CONV && fell_c, "R6", fr_rises, CONV);
          // R7 / R8
          chk(rd_data == frame_word, i_adc_sync_reader.mode_q ? "R8" : "R7",
              rd_data, frame_word);
          last_word = frame_word;
          prev_b15 = frame_word[DW-1];
          frames_done++;
        end
        adc_dout = prev_b15;
      end
      // R9
      chk(rd_valid == (cs_rose && !expect_tmo), "R9", rd_valid, cs_rose && !expect_tmo);

      prev_clk = adc_clk; prev_cs = adc_cs_n; prev_rstn = adc_rst_n; prev_busy = busy;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy === 1'b1 && !finished);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_conv(input logic [DW-1:0] w, input logic m);
    cur_word = w;
    cap_fall = m;
    pulse_start();
    // R5
    chk(busy == 1'b1, "R5", busy, 1);
    wait_idle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int fs, fd, tc;
    frames_started = 0; frames_done = 0; tmo_hits = 0; cal_ends = 0;
    rst_n = 1'b0; start = 1'b0; cap_fall = 1'b0; cal_on_eoc = 1'b0;
    tmo_lim = TMO_W'(1_000_000); cur_word = '0; expect_tmo = 0; tmo_L = 0;
    eoc_drop_cfg = 500; adc_eoc = 1'b1; adc_dout = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R2 reset state
    chk(adc_rst_n == 1'b0 && adc_cs_n == 1'b1 && adc_conv_n == 1'b1, "R2", {adc_rst_n, adc_cs_n, adc_conv_n}, 3'b011);
    chk(busy == 1'b1 && rd_valid == 1'b0 && tmo_err == 1'b0 && rd_data == '0, "R2", {busy, rd_valid, tmo_err}, 3'b100);
    chk(adc_clk == 1'b0, "R1", adc_clk, 0);
    @(negedge clk); #5 rst_n = 1'b1;

    // R10 start during calibration is ignored
    repeat (2000) @(negedge clk);
    pulse_start();
    wait_idle();
    repeat (4) @(negedge clk);
    chk(cal_ends == 1, "R3", cal_ends, 1);

    // R7 rising-edge capture, R8 falling-edge capture
    run_conv(16'hA5C3, 1'b0);
    run_conv(16'h0001, 1'b0);
    run_conv(16'hFFFF, 1'b0);
    run_conv(16'h8000, 1'b1);
    run_conv(16'h7FFE, 1'b1);
    run_conv(16'h3C5A, 1'b1);
    chk(frames_done == 6, "R9", frames_done, 6);

    // R10 start during a conversion is ignored
    fs = frames_started;
    cur_word = 16'h1234; cap_fall = 1'b0;
    pulse_start();
    do @(negedge clk); while (adc_cs_n);
    repeat (10) @(negedge clk);
    pulse_start();
    wait_idle();
    repeat (60) @(negedge clk);
    chk(frames_started == fs + 1, "R10", frames_started, fs + 1);
    chk(busy == 1'b0 && adc_cs_n == 1'b1, "R10", {busy, adc_cs_n}, 2'b01);

    // R11 timeout aborts the frame
    fd = frames_done; tc = tmo_hits;
    tmo_lim = TMO_W'(30); tmo_L = 30; expect_tmo = 1; cur_word = 16'hBEEF;
    pulse_start();
    wait_idle();
    repeat (3) @(negedge clk);
    chk(tmo_hits == tc + 1, "R11", tmo_hits, tc + 1);
    chk(frames_done == fd, "R11", frames_done, fd);
    chk(rd_data == 16'h1234, "R11", rd_data, 16'h1234);
    expect_tmo = 0; tmo_lim = TMO_W'(1_000_000);
    repeat (3) @(negedge clk);
    run_conv(16'hBEEF, 1'b0);

    // R4 calibration ended by end-of-conversion flag
    cal_on_eoc = 1'b1; eoc_drop_cfg = 300;
    @(negedge clk); #3 rst_n = 1'b0;
    frames_started = 0;
    repeat (3) @(negedge clk);
    #5 rst_n = 1'b1;
    fs = cal_ends;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(cal_ends == fs + 1, "R4", cal_ends, fs + 1);
    run_conv(16'h5AA5, 1'b1);
    run_conv(16'hC001, 1'b0);

    summary();
    $finish;
  end
endmodule